// File: doc/BRIEF.md
# Bidirectional Strobe/Acknowledge Byte Port

This block moves bytes across an eight-bit parallel port using two control wires: an active-low data strobe and an acknowledge (ready) line. A mode input chooses the direction. When receiving, an external sender places a byte on the port and pulls the strobe low. The block captures the byte, pulls its ready output low, and hands the byte to the core through a valid/ready interface. When sending, the block takes a byte from the core, drives it onto the port, pulls its strobe output low, and then follows the receiver's ready line.

In both directions every transfer follows the same four-step interlock. First the strobe falls. Then ready falls. Then the strobe rises. Last, ready rises. The two external control inputs each pass through a two-flop synchroniser before the control logic uses them. The port data is delayed through the same number of stages, so the byte that is captured is the one sampled together with the strobe edge.

A change of the mode input while a transfer is in progress is held off until the block is idle again.

Top module: `hsp_port`

## Requirements
- R1: After reset the block is in receive mode (modeSel 0 = receive, 1 = send). In this state readyOut=1, strobeNOut=1, rxValid=0, portDataOe=0 and txReady=0.
- R2: In receive mode, readyOut falls only while extStrobeNIn is low. The byte on portDataIn at the strobe fall is then presented on rxData with rxValid=1.
- R3: After a capture, readyOut stays low until extStrobeNIn is high again and the core has taken the byte (rxValid and rxReady high at one clock edge). While the byte waits, rxData does not change and no further byte is captured.
- R4: In send mode with the block idle, txReady=1. An accepted txData byte appears on portDataOut with portDataOe=1 at least one clock before strobeNOut goes low.
- R5: In send mode, strobeNOut rises only after extReadyIn has gone low during the strobe-low period. portDataOut does not change while strobeNOut is low.
- R6: strobeNOut falls only while extReadyIn is high. After a transfer, the next fall waits until extReadyIn has risen again.
- R7: A change of modeSel during a transfer takes effect only once the transfer is back to idle. Until then, portDataOe and the strobe sequence of the transfer in flight continue unchanged.
- R8: In each direction, every byte is delivered exactly once and in order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | Direction request: 0 receive, 1 send |
| portDataIn | input | DATA_W | Byte sampled from the port in receive mode |
| portDataOut | output | DATA_W | Byte driven onto the port in send mode |
| portDataOe | output | 1 | High while the block drives the port (send mode) |
| extStrobeNIn | input | 1 | Sender's active-low strobe (receive mode) |
| strobeNOut | output | 1 | Block's active-low strobe (send mode) |
| extReadyIn | input | 1 | Receiver's ready line (send mode) |
| readyOut | output | 1 | Block's ready line (receive mode) |
| rxValid | output | 1 | Captured byte available to the core |
| rxData | output | DATA_W | Captured byte |
| rxReady | input | 1 | Core takes the captured byte |
| txValid | input | 1 | Core offers a byte to send |
| txData | input | DATA_W | Byte to send |
| txReady | output | 1 | Block accepts the offered byte |

## Verification
Two events can land on the same clock in receive mode: the core takes the held byte, and the synchronised strobe returns high. Together they release readyOut. The consumer model toggles rxReady in a stall pattern while the sender model releases its strobe, so the take sometimes comes before, sometimes after and sometimes on the same edge as the strobe rise. Each case is judged by readyOut rising only with the strobe high, and by the scoreboard receiving every byte exactly once.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam logic MODE_RX = 1'b0;
  localparam logic MODE_TX = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_BUSY,
    ST_TX_SETUP,
    ST_TX_STROBE,
    ST_TX_RELEASE
  } hspState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureRx;
    logic loadTx;
  } hspCtrl_t;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int STAGES = 2,
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/hsp_datapath.sv
module hsp_datapath
  import hsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hspCtrl_t          ctrl,
  input  logic [DATA_W-1:0] portDataIn,
  input  logic              extStrobeNIn,
  input  logic              extReadyIn,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxReady,
  output logic              strobeSync,
  output logic              readySync,
  output logic              rxFull,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] portDataOut
);
  logic [DATA_W-1:0] dataSync;

  hsp_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b1)) uStrobeSync (
    .clk(clk), .rstN(rstN), .d(extStrobeNIn), .q(strobeSync));

  hsp_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b1)) uReadySync (
    .clk(clk), .rstN(rstN), .d(extReadyIn), .q(readySync));

  // data delayed alongside the strobe so capture matches the fall sample
  hsp_sync #(.STAGES(SYNC_STAGES), .W(DATA_W), .RST_VAL('0)) uDataSync (
    .clk(clk), .rstN(rstN), .d(portDataIn), .q(dataSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxData <= '0;
    end else if (ctrl.captureRx) begin
      rxFull <= 1'b1;
      rxData <= dataSync;
    end else if (rxFull && rxReady) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portDataOut <= '0;
    else if (ctrl.loadTx) portDataOut <= txData;
  end

  // R3: a held byte is never overwritten
  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.captureRx |-> !rxFull);
  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rxReady) |=> (rxFull && $stable(rxData)));
endmodule

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
  import hsp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     modeSel,
  input  logic     strobeSync,
  input  logic     readySync,
  input  logic     rxFull,
  input  logic     txValid,
  output hspCtrl_t ctrl,
  output logic     readyOut,
  output logic     strobeNOut,
  output logic     txReady,
  output logic     txMode
);
  hspState_t state, stateNxt;
  logic curMode, modeNxt;

  always_comb begin
    stateNxt = state;
    modeNxt = curMode;
    ctrl = '0;
    case (state)
      ST_IDLE: begin
        if (modeSel != curMode) begin
          modeNxt = modeSel;
        end else if (curMode == MODE_RX) begin
          if (!strobeSync) begin
            ctrl.captureRx = 1'b1;
            stateNxt = ST_RX_BUSY;
          end
        end else if (txValid) begin
          ctrl.loadTx = 1'b1;
          stateNxt = ST_TX_SETUP;
        end
      end
      ST_RX_BUSY:    if (strobeSync && !rxFull) stateNxt = ST_IDLE;
      ST_TX_SETUP:   if (readySync) stateNxt = ST_TX_STROBE;
      ST_TX_STROBE:  if (!readySync) stateNxt = ST_TX_RELEASE;
      ST_TX_RELEASE: if (readySync) stateNxt = ST_IDLE;
      default:       stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curMode <= MODE_RX;
    end else begin
      state <= stateNxt;
      curMode <= modeNxt;
    end
  end

  assign readyOut   = (state != ST_RX_BUSY);
  assign strobeNOut = (state != ST_TX_STROBE);
  assign txReady    = (state == ST_IDLE) && (curMode == MODE_TX) && (modeSel == MODE_TX);
  assign txMode     = curMode;

  // R2: ready falls only after a seen strobe fall
  assert_ready_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyOut) |-> $past(!strobeSync));
  // R3: ready rises only with strobe released
  assert_ready_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> $past(strobeSync));
  // R6: strobe falls only with receiver ready
  assert_strobe_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeNOut) |-> $past(readySync));
  // R5: strobe released only after ready went low
  assert_strobe_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeNOut) |-> $past(!readySync));
  // R7: mode changes only from idle
  assert_mode_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curMode != $past(curMode)) |-> $past(state == ST_IDLE));
endmodule

// File: rtl/hsp_port.sv
module hsp_port
  import hsp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic [DATA_W-1:0] portDataIn,
  output logic [DATA_W-1:0] portDataOut,
  output logic              portDataOe,
  input  logic              extStrobeNIn,
  output logic              strobeNOut,
  input  logic              extReadyIn,
  output logic              readyOut,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxReady,
  input  logic              txValid,
  input  logic [DATA_W-1:0] txData,
  output logic              txReady
);
  hspCtrl_t ctrl;
  logic strobeSync, readySync, rxFull, txMode;

  hsp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .strobeSync(strobeSync), .readySync(readySync), .rxFull(rxFull),
    .txValid(txValid), .ctrl(ctrl), .readyOut(readyOut),
    .strobeNOut(strobeNOut), .txReady(txReady), .txMode(txMode));

  hsp_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .portDataIn(portDataIn),
    .extStrobeNIn(extStrobeNIn), .extReadyIn(extReadyIn), .txData(txData),
    .rxReady(rxReady), .strobeSync(strobeSync), .readySync(readySync),
    .rxFull(rxFull), .rxData(rxData), .portDataOut(portDataOut));

  assign rxValid    = rxFull;
  assign portDataOe = (txMode == MODE_TX);

  // R4: data is on the port before the strobe falls
  assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobeNOut) |-> ($past(portDataOe) && $stable(portDataOut)));
  // R5: data steady while strobe is low
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeNOut && !$fell(strobeNOut)) |-> $stable(portDataOut));
endmodule

// File: tb/hsp_port_test.sv
module hsp_port_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic [7:0] portDataIn = '0;
  logic [7:0] portDataOut;
  logic portDataOe;
  logic extStrobeNIn = 1'b1;
  logic strobeNOut;
  logic extReadyIn = 1'b1;
  logic readyOut;
  logic rxValid;
  logic [7:0] rxData;
  logic rxReady = 1'b0;
  logic txValid = 1'b0;
  logic [7:0] txData = '0;
  logic txReady;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit consumeEn = 1'b1;
  bit stallPat = 1'b0;
  int ackDelay = 1;
  int raiseDelay = 2;
  logic [7:0] rxExp[$];
  logic [7:0] txExp[$];

  always #10 clk = ~clk;  // 50 MHz

  hsp_port uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // core-side consumer (receive direction)
  initial forever begin
    @(negedge clk);
    rxReady = consumeEn && (!stallPat || cyc[1]);
    if (rxValid && rxReady) begin
      if (rxExp.size() == 0) chk(0, "R8", "extra rx byte", rxData, 0);
      else begin
        logic [7:0] e;
        e = rxExp.pop_front();
        chk(rxData == e, "R8", "rx byte order", rxData, e);
      end
    end
  end

  // external receiver partner (send direction)
  initial forever begin
    @(negedge clk);
    if (!strobeNOut && extReadyIn) begin
      if (txExp.size() == 0) chk(0, "R8", "extra tx byte", portDataOut, 0);
      else begin
        logic [7:0] e;
        e = txExp.pop_front();
        chk(portDataOut == e, "R8", "tx byte order", portDataOut, e);
      end
      repeat (ackDelay) @(negedge clk);
      extReadyIn = 1'b0;
      while (!strobeNOut) @(negedge clk);
      repeat (raiseDelay) @(negedge clk);
      extReadyIn = 1'b1;
    end
  end

  // protocol monitor: edge order in both directions
  logic prevStrobe = 1'b1, prevReady = 1'b1, readyLowSeen = 1'b0, holdFault = 1'b0;
  logic [7:0] prevData = '0, fallData = '0;
  initial forever begin
    @(negedge clk); #2;
    if (rstN) begin
      if (prevStrobe && !strobeNOut) begin
        chk(extReadyIn == 1'b1, "R6", "strobe fell with ready low", extReadyIn, 1);
        chk(portDataOe && portDataOut == prevData, "R4", "data not set up before strobe",
            portDataOut, prevData);
        fallData = portDataOut;
        readyLowSeen = 1'b0;
        holdFault = 1'b0;
      end
      if (!strobeNOut && !extReadyIn) readyLowSeen = 1'b1;
      if (!strobeNOut && portDataOut != fallData) holdFault = 1'b1;
      if (!prevStrobe && strobeNOut)
        chk(readyLowSeen && !holdFault, "R5", "strobe rise order/hold",
            {readyLowSeen, holdFault}, 2);
      if (prevReady && !readyOut)
        chk(extStrobeNIn == 1'b0, "R2", "ready fell without strobe", extStrobeNIn, 0);
      if (!prevReady && readyOut)
        chk(extStrobeNIn == 1'b1, "R3", "ready rose with strobe low", extStrobeNIn, 1);
    end
    prevStrobe = strobeNOut;
    prevReady = readyOut;
    prevData = portDataOut;
  end

  task automatic sendByte(input logic [7:0] b);
    while (!readyOut) @(negedge clk);
    portDataIn = b;
    @(negedge clk);
    extStrobeNIn = 1'b0;
    rxExp.push_back(b);
    while (readyOut) @(negedge clk);
    @(negedge clk);
    portDataIn = ~b;
    extStrobeNIn = 1'b1;
  endtask

  task automatic writeByte(input logic [7:0] b);
    txValid = 1'b1;
    txData = b;
    while (!txReady) @(negedge clk);
    txExp.push_back(b);
    @(negedge clk);
    txValid = 1'b0;
    txData = ~b;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(readyOut == 1, "R1", "readyOut after reset", readyOut, 1);
    chk(strobeNOut == 1, "R1", "strobeNOut after reset", strobeNOut, 1);
    chk(rxValid == 0, "R1", "rxValid after reset", rxValid, 0);
    chk(portDataOe == 0, "R1", "portDataOe after reset", portDataOe, 0);
    chk(txReady == 0, "R1", "txReady after reset", txReady, 0);

    // R2 receive, free-running consumer
    sendByte(8'h3C);
    sendByte(8'hA5);
    sendByte(8'h00);
    sendByte(8'hFF);

    // R3 back-pressure: byte held, ready kept low
    while (!readyOut) @(negedge clk);
    consumeEn = 1'b0;
    sendByte(8'h5A);
    repeat (10) @(negedge clk);
    chk(readyOut == 0, "R3", "ready low while byte held", readyOut, 0);
    chk(rxValid == 1, "R3", "rxValid while held", rxValid, 1);
    chk(rxData == 8'h5A, "R2", "captured byte", rxData, 8'h5A);
    consumeEn = 1'b1;
    repeat (6) @(negedge clk);
    chk(readyOut == 1, "R3", "ready back after take", readyOut, 1);

    // stall pattern: take and strobe rise collide at varied offsets
    stallPat = 1'b1;
    for (int i = 0; i < 6; i++) sendByte(8'h10 + 8'(i * 7));
    repeat (12) @(negedge clk);
    stallPat = 1'b0;

    // R4 switch to send mode
    modeSel = 1'b1;
    repeat (3) @(negedge clk);
    chk(portDataOe == 1, "R4", "portDataOe in send mode", portDataOe, 1);
    chk(txReady == 1, "R4", "txReady when idle", txReady, 1);
    writeByte(8'hC3);
    writeByte(8'h81);
    writeByte(8'h7E);
    writeByte(8'h01);

    // R6 slow ready rise: next strobe must wait
    ackDelay = 5;
    raiseDelay = 12;
    writeByte(8'h96);
    writeByte(8'h69);
    writeByte(8'hE7);

    // R7 mode change mid-transfer
    ackDelay = 15;
    raiseDelay = 2;
    writeByte(8'h44);
    while (strobeNOut) @(negedge clk);
    modeSel = 1'b0;
    repeat (4) @(negedge clk);
    chk(portDataOe == 1, "R7", "OE kept during transfer", portDataOe, 1);
    chk(strobeNOut == 0, "R7", "strobe kept during transfer", strobeNOut, 0);
    while (!strobeNOut) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(portDataOe == 0, "R7", "OE dropped after idle", portDataOe, 0);
    chk(readyOut == 1, "R7", "receive idle after switch", readyOut, 1);
    sendByte(8'hB2);
    repeat (12) @(negedge clk);

    // R8 nothing lost or left over
    chk(rxExp.size() == 0, "R8", "rx bytes outstanding", rxExp.size(), 0);
    chk(txExp.size() == 0, "R8", "tx bytes outstanding", txExp.size(), 0);
    summary();
    $finish;
  end
endmodule